// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

This block sits between the interrupt sources that belong to each of four processor cores and the cores' own interrupt inputs. Every core has four timer lines and four mailbox levels of its own; two further lines, one from the graphics subsystem and one from the performance monitor, are shared by all cores. Registers written over a simple 32-bit bus decide which of these sources reach each core and whether they arrive on the normal interrupt line (IRQ) or on the fast interrupt line (FIQ).

For each core the block forms two 10-bit pending words, one for IRQ and one for FIQ. Software reads them to find the cause of an interrupt. The core's IRQ output is the OR of its IRQ pending word and its FIQ output is the OR of its FIQ pending word. Both outputs are registered. Any source that is enabled for both kinds of delivery is delivered as FIQ and never as IRQ.

The bus is a single-cycle write strobe and a read strobe. Read data is registered: it appears one cycle after the read strobe and holds until the next read.

Top module: `core_irq_router`

## Requirements
- R1: Synchronous reset clears every timer, mailbox and performance-monitor enable and sets both graphics routing fields to core 0. Reset also drives irq_out, fiq_out and rdata to zero.
- R2: The timer control word of core c is at offset 0x40+4c. Bits 3:0 enable IRQ delivery of timers 0..3 and bits 7:4 enable FIQ delivery of them. It reads back with bits 31:8 zero.
- R3: The mailbox control word of core c is at offset 0x50+4c. Bits 3:0 enable IRQ delivery of mailboxes 0..3 and bits 7:4 enable FIQ delivery of them. It reads back in the same layout.
- R4: A source whose FIQ enable is set is delivered only as FIQ, whatever the state of its IRQ enable.
- R5: The IRQ pending word of core c reads at 0x60+4c and the FIQ pending word at 0x70+4c. Bits 3:0 are timers 0..3, bits 7:4 are mailboxes 0..3, bit 8 is the graphics line and bit 9 is the performance monitor. Bits 31:10 are zero.
- R6: Offset 0x0C holds the graphics routing. Bits 1:0 name the core that gets the line as IRQ and bits 3:2 name the core that gets it as FIQ. When both fields name the same core, that core gets it as FIQ only.
- R7: Writing ones to bits of offset 0x10 sets performance-monitor enables and writing ones to offset 0x14 clears them. Zero bits leave their enables unchanged. Bit c (c=0..3) is core c's IRQ enable and bit 4+c is its FIQ enable. A read of either offset returns the current enable word.
- R8: irq_out[c] is the OR of core c's IRQ pending bits and fiq_out[c] is the OR of its FIQ pending bits. Each is registered, so it follows an input change at the next clock edge.
- R9: Reads of any offset not listed above return zero. Writes to the pending words or to unlisted offsets change no register.
- R10: rdata is loaded only on a cycle with rd_en high, one cycle after the strobe, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| timer_in | input | 16 | Timer lines, core c uses bits 4c+3..4c |
| mbox_in | input | 16 | Mailbox pending levels, core c uses bits 4c+3..4c |
| gpu_in | input | 1 | Shared graphics interrupt |
| pmu_in | input | 1 | Shared performance-monitor interrupt |
| irq_out | output | 4 | IRQ line of each core |
| fiq_out | output | 4 | FIQ line of each core |

## Verification
All state in this block is either an enable word or a routing field, so a wrong bit is visible in two ways. It shows directly through the read port, and it shows as a missing, extra or misplaced interrupt on irq_out or fiq_out at the first clock edge after the affected source goes high. The bench programs a mixed configuration: IRQ-only, FIQ-only and doubly enabled sources, plus graphics routing split across two cores. It then drives each source alone and all sources together, so a swapped field or a broken FIQ override shows within one cycle of the stimulus. The pending words of every core are read back bit by bit to pin down the field layout. Set/clear behaviour, same-core graphics routing and a reset during operation are each checked through both the outputs and readback.

// File: rtl/cir_pkg.sv
package cir_pkg;
  // Fixed offsets of the shared registers
  localparam int unsigned OFS_GPU_ROUTE = 32'h0C;
  localparam int unsigned OFS_PMU_SET   = 32'h10;
  localparam int unsigned OFS_PMU_CLR   = 32'h14;
  // Per-core register groups, selected by addr[7:4]; core index in addr[3:2]
  localparam int unsigned GRP_TMR_CTL   = 4;
  localparam int unsigned GRP_MBX_CTL   = 5;
  localparam int unsigned GRP_IRQ_PEND  = 6;
  localparam int unsigned GRP_FIQ_PEND  = 7;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_GPU,
    SEL_PMU_SET,
    SEL_PMU_CLR,
    SEL_TMR,
    SEL_MBX,
    SEL_IPEND,
    SEL_FPEND
  } reg_sel_e;
endpackage

// File: rtl/cir_decode.sv
module cir_decode
  import cir_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [CORE_W-1:0] core
);
  localparam int GRP_W = ADDR_W - 4;

  logic [GRP_W-1:0] grp;
  logic             slot_ok;

  assign grp     = addr[ADDR_W-1:4];
  assign core    = addr[2 +: CORE_W];
  assign slot_ok = (addr[1:0] == 2'b00) && (int'(addr[3:2]) < NUM_CORES);

  always_comb begin
    sel = SEL_NONE;
    if (addr == ADDR_W'(OFS_GPU_ROUTE))       sel = SEL_GPU;
    else if (addr == ADDR_W'(OFS_PMU_SET))    sel = SEL_PMU_SET;
    else if (addr == ADDR_W'(OFS_PMU_CLR))    sel = SEL_PMU_CLR;
    else if (slot_ok) begin
      if (grp == GRP_W'(GRP_TMR_CTL))         sel = SEL_TMR;
      else if (grp == GRP_W'(GRP_MBX_CTL))    sel = SEL_MBX;
      else if (grp == GRP_W'(GRP_IRQ_PEND))   sel = SEL_IPEND;
      else if (grp == GRP_W'(GRP_FIQ_PEND))   sel = SEL_FPEND;
    end
  end
endmodule

// File: rtl/cir_regs.sv
module cir_regs
  import cir_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int TMR_N     = 4,
  parameter int MBX_N     = 4,
  parameter int DATA_W    = 32,
  parameter int CORE_W    = 2
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 wr_en,
  input  reg_sel_e                             sel,
  input  logic [CORE_W-1:0]                    core,
  input  logic [DATA_W-1:0]                    wdata,
  output logic [NUM_CORES-1:0][2*TMR_N-1:0]    tmr_ctl,
  output logic [NUM_CORES-1:0][2*MBX_N-1:0]    mbx_ctl,
  output logic [CORE_W-1:0]                    gpu_irq_core,
  output logic [CORE_W-1:0]                    gpu_fiq_core,
  output logic [2*NUM_CORES-1:0]               pmu_en
);
  localparam int TCTL_W = 2 * TMR_N;
  localparam int MCTL_W = 2 * MBX_N;
  localparam int PMU_W  = 2 * NUM_CORES;

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_ctl
    always_ff @(posedge clk) begin
      if (rst) begin
        tmr_ctl[c] <= '0;
        mbx_ctl[c] <= '0;
      end else if (wr_en && core == CORE_W'(c)) begin
        if (sel == SEL_TMR) tmr_ctl[c] <= wdata[TCTL_W-1:0];
        if (sel == SEL_MBX) mbx_ctl[c] <= wdata[MCTL_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gpu_irq_core <= '0;
      gpu_fiq_core <= '0;
      pmu_en       <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_GPU: begin
          gpu_irq_core <= wdata[CORE_W-1:0];
          gpu_fiq_core <= wdata[2*CORE_W-1:CORE_W];
        end
        SEL_PMU_SET: pmu_en <= pmu_en | wdata[PMU_W-1:0];
        SEL_PMU_CLR: pmu_en <= pmu_en & ~wdata[PMU_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cir_core_route.sv
module cir_core_route #(
  parameter int CORE_ID = 0,
  parameter int TMR_N   = 4,
  parameter int MBX_N   = 4,
  parameter int CORE_W  = 2,
  parameter int PEND_W  = TMR_N + MBX_N + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TMR_N-1:0]   tmr_in,
  input  logic [MBX_N-1:0]   mbx_in,
  input  logic               gpu_in,
  input  logic               pmu_in,
  input  logic [2*TMR_N-1:0] tmr_ctl,
  input  logic [2*MBX_N-1:0] mbx_ctl,
  input  logic [CORE_W-1:0]  gpu_irq_core,
  input  logic [CORE_W-1:0]  gpu_fiq_core,
  input  logic               pmu_ien,
  input  logic               pmu_fen,
  output logic [PEND_W-1:0]  irq_pend,
  output logic [PEND_W-1:0]  fiq_pend,
  output logic               irq_q,
  output logic               fiq_q
);
  logic [TMR_N-1:0] t_ien, t_fen;
  logic [MBX_N-1:0] m_ien, m_fen;
  logic             gpu_to_irq, gpu_to_fiq;

  assign t_ien = tmr_ctl[TMR_N-1:0];
  assign t_fen = tmr_ctl[2*TMR_N-1:TMR_N];
  assign m_ien = mbx_ctl[MBX_N-1:0];
  assign m_fen = mbx_ctl[2*MBX_N-1:MBX_N];

  assign gpu_to_irq = (gpu_irq_core == CORE_W'(CORE_ID));
  assign gpu_to_fiq = (gpu_fiq_core == CORE_W'(CORE_ID));

  // FIQ selection wins over IRQ selection for every source
  assign fiq_pend = {pmu_in & pmu_fen,
                     gpu_in & gpu_to_fiq,
                     mbx_in & m_fen,
                     tmr_in & t_fen};
  assign irq_pend = {pmu_in & pmu_ien & ~pmu_fen,
                     gpu_in & gpu_to_irq & ~gpu_to_fiq,
                     mbx_in & m_ien & ~m_fen,
                     tmr_in & t_ien & ~t_fen};

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else begin
      irq_q <= |irq_pend;
      fiq_q <= |fiq_pend;
    end
  end
endmodule

// File: rtl/core_irq_router.sv
module core_irq_router
  import cir_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int TMR_N     = 4,
  parameter int MBX_N     = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  input  logic [NUM_CORES*TMR_N-1:0] timer_in,
  input  logic [NUM_CORES*MBX_N-1:0] mbox_in,
  input  logic                       gpu_in,
  input  logic                       pmu_in,
  output logic [NUM_CORES-1:0]       irq_out,
  output logic [NUM_CORES-1:0]       fiq_out
);
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
  localparam int PEND_W = TMR_N + MBX_N + 2;

  reg_sel_e                           sel;
  logic [CORE_W-1:0]                  core;
  logic [NUM_CORES-1:0][2*TMR_N-1:0]  tmr_ctl;
  logic [NUM_CORES-1:0][2*MBX_N-1:0]  mbx_ctl;
  logic [CORE_W-1:0]                  gpu_irq_core, gpu_fiq_core;
  logic [2*NUM_CORES-1:0]             pmu_en;
  logic [NUM_CORES-1:0][PEND_W-1:0]   ipend, fpend;
  logic [DATA_W-1:0]                  rd_mux;

  cir_decode #(.ADDR_W(ADDR_W), .NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) u_dec (
    .addr (addr),
    .sel  (sel),
    .core (core)
  );

  cir_regs #(
    .NUM_CORES(NUM_CORES), .TMR_N(TMR_N), .MBX_N(MBX_N),
    .DATA_W(DATA_W), .CORE_W(CORE_W)
  ) u_regs (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .sel          (sel),
    .core         (core),
    .wdata        (wdata),
    .tmr_ctl      (tmr_ctl),
    .mbx_ctl      (mbx_ctl),
    .gpu_irq_core (gpu_irq_core),
    .gpu_fiq_core (gpu_fiq_core),
    .pmu_en       (pmu_en)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    cir_core_route #(
      .CORE_ID(c), .TMR_N(TMR_N), .MBX_N(MBX_N),
      .CORE_W(CORE_W), .PEND_W(PEND_W)
    ) u_route (
      .clk          (clk),
      .rst          (rst),
      .tmr_in       (timer_in[c*TMR_N +: TMR_N]),
      .mbx_in       (mbox_in[c*MBX_N +: MBX_N]),
      .gpu_in       (gpu_in),
      .pmu_in       (pmu_in),
      .tmr_ctl      (tmr_ctl[c]),
      .mbx_ctl      (mbx_ctl[c]),
      .gpu_irq_core (gpu_irq_core),
      .gpu_fiq_core (gpu_fiq_core),
      .pmu_ien      (pmu_en[c]),
      .pmu_fen      (pmu_en[NUM_CORES+c]),
      .irq_pend     (ipend[c]),
      .fiq_pend     (fpend[c]),
      .irq_q        (irq_out[c]),
      .fiq_q        (fiq_out[c])
    );
  end

  always_comb begin
    case (sel)
      SEL_GPU:     rd_mux = DATA_W'({gpu_fiq_core, gpu_irq_core});
      SEL_PMU_SET,
      SEL_PMU_CLR: rd_mux = DATA_W'(pmu_en);
      SEL_TMR:     rd_mux = DATA_W'(tmr_ctl[core]);
      SEL_MBX:     rd_mux = DATA_W'(mbx_ctl[core]);
      SEL_IPEND:   rd_mux = DATA_W'(ipend[core]);
      SEL_FPEND:   rd_mux = DATA_W'(fpend[core]);
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/cir_checks.sv
module cir_checks #(
  parameter int NUM_CORES = 4,
  parameter int TMR_N     = 4,
  parameter int MBX_N     = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       rd_en,
  input logic [ADDR_W-1:0]          addr,
  input logic [DATA_W-1:0]          rdata,
  input logic [NUM_CORES*TMR_N-1:0] timer_in,
  input logic [NUM_CORES*MBX_N-1:0] mbox_in,
  input logic                       gpu_in,
  input logic                       pmu_in,
  input logic [NUM_CORES-1:0]       irq_out,
  input logic [NUM_CORES-1:0]       fiq_out
);
  logic [ADDR_W-5:0] grp;
  logic              known_ofs;
  logic              quiet;
  logic              gpu_alone;

  assign grp       = addr[ADDR_W-1:4];
  assign known_ofs = (addr == ADDR_W'(8'h0C)) || (addr == ADDR_W'(8'h10)) ||
                     (addr == ADDR_W'(8'h14)) ||
                     ((addr[1:0] == 2'b00) && (int'(grp) >= 4) && (int'(grp) <= 7));
  assign quiet     = (timer_in == '0) && (mbox_in == '0) && !gpu_in && !pmu_in;
  assign gpu_alone = (timer_in == '0) && (mbox_in == '0) && gpu_in && !pmu_in;

  // R1: leaving reset, all outputs are low
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_out == '0 && fiq_out == '0 && rdata == '0));

  // R8: with no source active, no core is interrupted one cycle later
  a_r8_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    quiet |=> (irq_out == '0 && fiq_out == '0));

  // R6: the graphics line alone raises exactly one FIQ and at most one IRQ
  a_r6_gpu_one_target: assert property (@(posedge clk) disable iff (rst)
    gpu_alone |=> ($countones(fiq_out) == 1 && $countones(irq_out) <= 1));

  // R9: unlisted offsets read as zero
  a_r9_undef_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !known_ofs) |=> (rdata == '0));

  // R10: read data holds without a read strobe
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

bind core_irq_router cir_checks #(
  .NUM_CORES(NUM_CORES), .TMR_N(TMR_N), .MBX_N(MBX_N),
  .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_checks (.*);

// File: tb/core_irq_router_test.sv
module core_irq_router_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] timer_in = '0, mbox_in = '0;
  logic        gpu_in = 1'b0, pmu_in = 1'b0;
  logic [3:0]  irq_out, fiq_out;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  core_irq_router uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .timer_in(timer_in), .mbox_in(mbox_in),
    .gpu_in(gpu_in), .pmu_in(pmu_in), .irq_out(irq_out), .fiq_out(fiq_out)
  );

  // Fields: timer_in[41:26] mbox_in[25:10] gpu[9] pmu[8] irq_exp[7:4] fiq_exp[3:0]
  // Under the configuration loaded below (R2, R3, R6, R7 settings).
  localparam int NVEC = 11;
  localparam logic [41:0] VEC [NVEC] = '{
    {16'h0000, 16'h0000, 1'b0, 1'b0, 4'b0000, 4'b0000},
    {16'h0001, 16'h0000, 1'b0, 1'b0, 4'b0001, 4'b0000},
    {16'h0020, 16'h0000, 1'b0, 1'b0, 4'b0000, 4'b0010},
    {16'h0400, 16'h0000, 1'b0, 1'b0, 4'b0000, 4'b0100},
    {16'hF000, 16'h0000, 1'b0, 1'b0, 4'b0000, 4'b0000},
    {16'h0002, 16'h0000, 1'b0, 1'b0, 4'b0000, 4'b0000},
    {16'h0000, 16'h0001, 1'b0, 1'b0, 4'b0000, 4'b0001},
    {16'h0000, 16'h8000, 1'b0, 1'b0, 4'b1000, 4'b0000},
    {16'h0000, 16'h0000, 1'b1, 1'b0, 4'b0100, 4'b0010},
    {16'h0000, 16'h0000, 1'b0, 1'b1, 4'b1000, 4'b0001},
    {16'h0421, 16'h8001, 1'b1, 1'b1, 4'b1101, 4'b0111}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic drive(input logic [15:0] t, input logic [15:0] m, input logic g, input logic p);
    @(negedge clk);
    timer_in = t; mbox_in = m; gpu_in = g; pmu_in = p;
  endtask

  task automatic load_config();
    wr(8'h40, 32'hABCD_0001);  // core0: timer0 IRQ (upper bits dropped)
    wr(8'h44, 32'h0000_0022);  // core1: timer1 IRQ+FIQ
    wr(8'h48, 32'h0000_0040);  // core2: timer2 FIQ
    wr(8'h50, 32'h0000_0010);  // core0: mailbox0 FIQ
    wr(8'h5C, 32'h0000_0008);  // core3: mailbox3 IRQ
    wr(8'h0C, 32'h0000_0006);  // graphics IRQ->core2, FIQ->core1
    wr(8'h10, 32'h0000_0018);  // pmu IRQ core3, FIQ core0
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 irq_out after reset", 32'(irq_out), 32'h0);
    chk("R1 fiq_out after reset", 32'(fiq_out), 32'h0);
    chk("R1 rdata after reset", rdata, 32'h0);
    rd(8'h0C, d); chk("R1 gpu routing reset", d, 32'h0);
    rd(8'h44, d); chk("R1 timer ctl reset", d, 32'h0);
    rd(8'h10, d); chk("R1 pmu enables reset", d, 32'h0);

    load_config();

    // R2, R3: readback and layout
    rd(8'h40, d); chk("R2 timer ctl core0 upper bits zero", d, 32'h01);
    rd(8'h44, d); chk("R2 timer ctl core1", d, 32'h22);
    rd(8'h5C, d); chk("R3 mailbox ctl core3", d, 32'h08);
    rd(8'h0C, d); chk("R6 gpu routing readback", d, 32'h06);
    rd(8'h14, d); chk("R7 pmu enables via clear offset", d, 32'h18);

    // R8 timing: output not yet changed before the edge, set after it
    drive(16'h0001, 16'h0, 1'b0, 1'b0);
    #1 chk("R8 irq before edge", 32'(irq_out), 32'h0);
    @(negedge clk);
    chk("R8 irq one edge later", 32'(irq_out), 32'h1);

    // Table walk: R4 (core1 doubly enabled -> FIQ only), R6, R7, R8
    for (int i = 0; i < NVEC; i++) begin
      logic [41:0] v;
      v = VEC[i];
      drive(v[41:26], v[25:10], v[9], v[8]);
      @(negedge clk);
      chk($sformatf("R4/R8 vec%0d irq_out", i), 32'(irq_out), 32'(v[7:4]));
      chk($sformatf("R4/R8 vec%0d fiq_out", i), 32'(fiq_out), 32'(v[3:0]));
    end

    // R5: pending words with all sources active (last vector still driven)
    rd(8'h60, d); chk("R5 core0 irq pend", d, 32'h001);
    rd(8'h70, d); chk("R5 core0 fiq pend", d, 32'h210);
    rd(8'h64, d); chk("R5 core1 irq pend", d, 32'h000);
    rd(8'h74, d); chk("R5 core1 fiq pend", d, 32'h102);
    rd(8'h68, d); chk("R5 core2 irq pend", d, 32'h100);
    rd(8'h78, d); chk("R5 core2 fiq pend", d, 32'h004);
    rd(8'h6C, d); chk("R5 core3 irq pend", d, 32'h280);
    rd(8'h7C, d); chk("R5 core3 fiq pend", d, 32'h000);

    // R10: rdata holds while inputs change and no read is issued
    drive(16'h0, 16'h0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R10 rdata held without read", rdata, 32'h000);

    // R6: same core named in both fields -> FIQ only
    wr(8'h0C, 32'h0);
    drive(16'h0, 16'h0, 1'b1, 1'b0);
    @(negedge clk);
    chk("R6 same core0 irq", 32'(irq_out), 32'h0);
    chk("R6 same core0 fiq", 32'(fiq_out), 32'h1);
    wr(8'h0C, 32'h0F);
    @(negedge clk);
    chk("R6 same core3 irq", 32'(irq_out), 32'h0);
    chk("R6 same core3 fiq", 32'(fiq_out), 32'h8);
    drive(16'h0, 16'h0, 1'b0, 1'b0);

    // R7: clear only the named bits
    wr(8'h14, 32'h10);
    rd(8'h10, d); chk("R7 after clearing core0 FIQ", d, 32'h08);
    drive(16'h0, 16'h0, 1'b0, 1'b1);
    @(negedge clk);
    chk("R7 pmu irq core3 remains", 32'(irq_out), 32'h8);
    chk("R7 pmu fiq cleared", 32'(fiq_out), 32'h0);
    wr(8'h14, 32'h08);
    @(negedge clk);
    chk("R7 pmu fully cleared irq", 32'(irq_out), 32'h0);
    wr(8'h10, 32'h0);
    rd(8'h10, d); chk("R7 zero set leaves enables", d, 32'h00);
    drive(16'h0, 16'h0, 1'b0, 1'b0);

    // R9: unlisted offsets and pending writes
    rd(8'h20, d); chk("R9 unlisted offset 0x20", d, 32'h0);
    rd(8'h42, d); chk("R9 misaligned offset 0x42", d, 32'h0);
    wr(8'h60, 32'hFFFF_FFFF);
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h60, d); chk("R9 pending write ignored", d, 32'h0);
    rd(8'h30, d); chk("R9 unlisted write reads zero", d, 32'h0);
    rd(8'h40, d); chk("R9 timer ctl untouched", d, 32'h01);
    rd(8'h0C, d); chk("R9 gpu routing untouched", d, 32'h0F);

    // R1: reset in operation clears configuration
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    rd(8'h40, d); chk("R1 timer ctl cleared by reset", d, 32'h0);
    rd(8'h0C, d); chk("R1 gpu routing back to core0", d, 32'h0);
    drive(16'h0001, 16'h0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R1 timer disabled after reset", 32'(irq_out), 32'h0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule